// File: doc/BRIEF.md
# Protected-Mode Interrupt Entry Sequencer

This block steps a CPU core through the memory traffic of taking an interrupt and of returning from one. When an interrupt request arrives with a vector number, the sequencer reads the handler's far address from a table in memory. In protected mode this address comes from an 8-byte gate selected by the vector. In real mode it comes from a 4-byte vector-table entry. A protected-mode gate is then checked for a usable type. The code-segment descriptor that the gate's selector names is fetched from the global or the local descriptor table into a code-segment cache. After that the sequencer pushes the return frame, hands back the new code selector, instruction pointer and stack pointer, and raises a one-cycle done pulse.

A return request pops the same kind of frame. Its operand size is given with the request. The sequencer then reports the restored instruction pointer, selector, flags and stack pointer. All memory traffic uses one request/acknowledge port. Reads are always 32 bits wide, and writes are 16 or 32 bits wide. Privilege, limit and access-right checks and stack switching are not part of the block.

The width of an interrupt frame depends only on the gate type. The default-operand-size bit of any code segment has no effect on it.

Top module: `intr_entry_seq`

## Requirements
- R1: In protected mode, the gate for vector v is read as two 32-bit words at table base + 8·v and + 8·v + 4. The handler offset is bits 15:0 of the first word plus bits 31:16 of the second word. The selector is bits 31:16 of the first word. The gate type is bits 11:8 of the second word. The new code selector output equals the gate selector. While a memory request waits for its acknowledge, the request and the address stay unchanged.
- R2: A gate of type 0x6 pushes three 16-bit writes: flags[15:0] at SP−2, the old code selector at SP−4 and IP[15:0] at SP−6. The new stack pointer is SP−6.
- R3: A gate of type 0xE pushes three 32-bit writes: flags at SP−4, the old code selector zero-extended at SP−8 and the full IP at SP−12. The new stack pointer is SP−12.
- R4: The new instruction pointer is the full 32-bit gate offset for type 0xE. For type 0x6 and in real mode it is offset[15:0] with bits 31:16 cleared.
- R5: Selector bit 2 picks the local table base, otherwise the global table base. The descriptor is read at base + (selector & 0xFFF8) as two words. The cache base is {hi[31:24], hi[7:0], lo[31:16]}. The cache limit is {hi[19:16], lo[15:0]}. The cache attributes are {hi[23:20], hi[15:8]}.
- R6: The default-size bit of the fetched descriptor (attribute bit 10) does not change the frame width or the stack pointer adjustment.
- R7: In real mode, one word at table base + 4·v is read: IP in bits 15:0 and CS in bits 31:16. No descriptor is read. The frame is always 16-bit, whatever the gate-type bits in memory hold. The cache base becomes CS·16 and the cache limit becomes 0xFFFF.
- R8: A protected-mode gate type other than 0x6 or 0xE produces a one-cycle fault pulse. No memory write is made, and the new selector, IP and SP outputs keep their previous values.
- R9: A 16-bit return reads IP[15:0] at SP, CS at SP+2 and flags[15:0] at SP+4. The new IP is zero-extended. The new flags take bits 31:16 from the current flags. The new stack pointer is SP+6.
- R10: A 32-bit return reads IP at SP, CS (low 16 bits) at SP+4 and flags at SP+8. The new stack pointer is SP+12. No memory write is made.
- R11: Interrupt and return requests arriving while the block is busy are ignored. Each accepted request ends in exactly one one-cycle done or fault pulse, never both.
- R12: After reset the block is idle with no memory request, no done or fault pulse, and all new-state and cache outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_en_i | input | 1 | Protected mode enabled |
| gate_base_i | input | AW | Base of the gate table / real-mode vector table |
| gdt_base_i | input | AW | Global descriptor table base |
| ldt_base_i | input | AW | Local descriptor table base |
| irq_req_i | input | 1 | Interrupt request (sampled when idle) |
| irq_vec_i | input | VEC_W | Interrupt vector number |
| iret_req_i | input | 1 | Return request (sampled when idle, loses to irq) |
| iret_wide_i | input | 1 | Return operand size: 1 = 32-bit pops |
| cur_cs_i | input | 16 | Current code selector |
| cur_ip_i | input | 32 | Current instruction pointer |
| cur_flags_i | input | 32 | Current flags |
| cur_sp_i | input | AW | Current stack pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_wide_o | output | 1 | Access size: 1 = 32-bit, 0 = 16-bit |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 32 | Write data, 16-bit writes in bits 15:0 |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data, little-endian |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle bad-gate pulse |
| new_cs_o | output | 16 | Resulting code selector |
| new_ip_o | output | 32 | Resulting instruction pointer |
| new_flags_o | output | 32 | Restored flags (updated by returns) |
| new_sp_o | output | AW | Resulting stack pointer |
| cs_base_o | output | 32 | Code-segment cache base |
| cs_limit_o | output | 20 | Code-segment cache limit |
| cs_attr_o | output | 12 | Code-segment cache attributes |

## Verification
The entry path is run with both valid gate types. Each type is paired with a descriptor whose size bit disagrees with the gate, which shows that the frame width follows the gate alone. Offsets with non-zero upper halves separate the zero-extended load from the full load. Selectors with bit 2 set and with nonzero low bits show the table choice and the masking. A real-mode entry whose table bits would decode as a 32-bit gate shows that real mode always forces 16-bit pushes. Gate types 0xF and 0x0 must fault with no writes. Returns of both sizes are run over frames whose unused upper halves hold non-zero data. Requests issued during a sequence must leave the result of the first request untouched.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_GATE_LO, ST_GATE_HI, ST_DESC_LO, ST_DESC_HI,
    ST_PUSH, ST_POP, ST_DONE, ST_FAULT
  } seq_st_e;

  localparam logic [3:0] GATE_T16 = 4'h6;
  localparam logic [3:0] GATE_T32 = 4'hE;
  localparam int unsigned FRAME_SLOTS = 3;
  localparam int unsigned GATE_SHIFT = 3;
  localparam int unsigned IVT_SHIFT = 2;
endpackage

// File: rtl/intr_gate_decode.sv
module intr_gate_decode
  import intr_seq_pkg::*;
(
  input  logic [31:0] lo_i,
  input  logic [31:0] hi_i,
  output logic [31:0] off_o,
  output logic [15:0] sel_o,
  output logic        valid_o,
  output logic        wide_o
);
  logic [3:0] gtype;
  logic       unused_gate_bits;

  assign off_o   = {hi_i[31:16], lo_i[15:0]};
  assign sel_o   = lo_i[31:16];
  assign gtype   = hi_i[11:8];
  assign wide_o  = (gtype == GATE_T32);
  assign valid_o = (gtype == GATE_T32) || (gtype == GATE_T16);
  assign unused_gate_bits = ^{hi_i[15:12], hi_i[7:0]};
endmodule

// File: rtl/intr_seg_decode.sv
module intr_seg_decode (
  input  logic [31:0] lo_i,
  input  logic [31:0] hi_i,
  output logic [31:0] base_o,
  output logic [19:0] limit_o,
  output logic [11:0] attr_o
);
  assign base_o  = {hi_i[31:24], hi_i[7:0], lo_i[31:16]};
  assign limit_o = {hi_i[19:16], lo_i[15:0]};
  assign attr_o  = {hi_i[23:20], hi_i[15:8]};
endmodule

// File: rtl/intr_frame_addr.sv
module intr_frame_addr #(
  parameter int AW = 32
) (
  input  logic [1:0]    step_i,
  input  logic          pop_i,
  input  logic          wide_i,
  input  logic [AW-1:0] sp_i,
  input  logic [31:0]   flags_i,
  input  logic [15:0]   cs_i,
  input  logic [31:0]   ip_i,
  output logic [AW-1:0] addr_o,
  output logic [31:0]   wdata_o
);
  logic [AW-1:0] slot;
  logic [AW-1:0] span;
  logic [31:0]   val;

  // push walks down from SP (flags first), pop walks up from SP (IP first)
  assign slot   = AW'(step_i) + (pop_i ? AW'(0) : AW'(1));
  assign span   = wide_i ? (slot << 2) : (slot << 1);
  assign addr_o = pop_i ? sp_i + span : sp_i - span;

  always_comb begin
    unique case (step_i)
      2'd0:    val = flags_i;
      2'd1:    val = {16'h0, cs_i};
      default: val = ip_i;
    endcase
  end

  assign wdata_o = wide_i ? val : {16'h0, val[15:0]};
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prot_en_i,
  input  logic [AW-1:0]    gate_base_i,
  input  logic [AW-1:0]    gdt_base_i,
  input  logic [AW-1:0]    ldt_base_i,
  input  logic             irq_req_i,
  input  logic [VEC_W-1:0] irq_vec_i,
  input  logic             iret_req_i,
  input  logic             iret_wide_i,
  input  logic [15:0]      cur_cs_i,
  input  logic [31:0]      cur_ip_i,
  input  logic [31:0]      cur_flags_i,
  input  logic [AW-1:0]    cur_sp_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic             mem_wide_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [15:0]      new_cs_o,
  output logic [31:0]      new_ip_o,
  output logic [31:0]      new_flags_o,
  output logic [AW-1:0]    new_sp_o,
  output logic [31:0]      cs_base_o,
  output logic [19:0]      cs_limit_o,
  output logic [11:0]      cs_attr_o
);
  localparam logic [1:0] LAST_STEP = 2'(FRAME_SLOTS - 1);

  seq_st_e          st_q;
  logic [1:0]       step_q;
  logic             pm_q, wide_q;
  logic [VEC_W-1:0] vec_q;
  logic [AW-1:0]    sp_q;
  logic [31:0]      flags_q, ip_q, g_lo_q, d_lo_q, h_off_q, pop_ip_q;
  logic [15:0]      cs_q, h_sel_q, pop_cs_q;

  logic [31:0] g_off;
  logic [15:0] g_sel;
  logic        g_valid, g_wide;
  logic [31:0] s_base;
  logic [19:0] s_limit;
  logic [11:0] s_attr;
  logic [AW-1:0] fr_addr, vec_ext, vec_off, desc_base, desc_addr, frame_bytes;
  logic [31:0]   fr_wdata;

  intr_gate_decode u_gate (
    .lo_i(g_lo_q), .hi_i(mem_rdata_i),
    .off_o(g_off), .sel_o(g_sel), .valid_o(g_valid), .wide_o(g_wide)
  );

  intr_seg_decode u_seg (
    .lo_i(d_lo_q), .hi_i(mem_rdata_i),
    .base_o(s_base), .limit_o(s_limit), .attr_o(s_attr)
  );

  intr_frame_addr #(.AW(AW)) u_frame (
    .step_i(step_q), .pop_i(st_q == ST_POP), .wide_i(wide_q), .sp_i(sp_q),
    .flags_i(flags_q), .cs_i(cs_q), .ip_i(ip_q),
    .addr_o(fr_addr), .wdata_o(fr_wdata)
  );

  assign vec_ext     = AW'(vec_q);
  assign vec_off     = pm_q ? (vec_ext << GATE_SHIFT) : (vec_ext << IVT_SHIFT);
  assign desc_base   = h_sel_q[2] ? ldt_base_i : gdt_base_i;
  assign desc_addr   = desc_base + AW'({h_sel_q[15:3], 3'b000});
  assign frame_bytes = wide_q ? AW'(12) : AW'(6);

  always_comb begin
    unique case (st_q)
      ST_GATE_LO: mem_addr_o = gate_base_i + vec_off;
      ST_GATE_HI: mem_addr_o = gate_base_i + vec_off + AW'(4);
      ST_DESC_LO: mem_addr_o = desc_addr;
      ST_DESC_HI: mem_addr_o = desc_addr + AW'(4);
      ST_PUSH,
      ST_POP:     mem_addr_o = fr_addr;
      default:    mem_addr_o = '0;
    endcase
  end

  assign mem_req_o   = st_q inside {ST_GATE_LO, ST_GATE_HI, ST_DESC_LO,
                                    ST_DESC_HI, ST_PUSH, ST_POP};
  assign mem_we_o    = (st_q == ST_PUSH);
  assign mem_wide_o  = (st_q == ST_PUSH) ? wide_q : 1'b1;
  assign mem_wdata_o = (st_q == ST_PUSH) ? fr_wdata : 32'h0;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign fault_o     = (st_q == ST_FAULT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      step_q <= '0; pm_q <= 1'b0; wide_q <= 1'b0; vec_q <= '0; sp_q <= '0;
      flags_q <= '0; ip_q <= '0; cs_q <= '0; g_lo_q <= '0; d_lo_q <= '0;
      h_off_q <= '0; h_sel_q <= '0; pop_ip_q <= '0; pop_cs_q <= '0;
      new_cs_o <= '0; new_ip_o <= '0; new_flags_o <= '0; new_sp_o <= '0;
      cs_base_o <= '0; cs_limit_o <= '0; cs_attr_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          step_q <= '0;
          if (irq_req_i) begin
            pm_q <= prot_en_i; vec_q <= irq_vec_i; sp_q <= cur_sp_i;
            flags_q <= cur_flags_i; cs_q <= cur_cs_i; ip_q <= cur_ip_i;
            wide_q <= 1'b0;
            st_q <= ST_GATE_LO;
          end else if (iret_req_i) begin
            sp_q <= cur_sp_i; flags_q <= cur_flags_i; wide_q <= iret_wide_i;
            st_q <= ST_POP;
          end
        end
        ST_GATE_LO: if (mem_ack_i) begin
          g_lo_q <= mem_rdata_i;
          if (pm_q) st_q <= ST_GATE_HI;
          else begin
            // real mode: offset/segment pair, frame forced narrow
            h_off_q    <= {16'h0, mem_rdata_i[15:0]};
            h_sel_q    <= mem_rdata_i[31:16];
            cs_base_o  <= {12'h0, mem_rdata_i[31:16], 4'h0};
            cs_limit_o <= 20'h0FFFF;
            st_q       <= ST_PUSH;
          end
        end
        ST_GATE_HI: if (mem_ack_i) begin
          if (!g_valid) st_q <= ST_FAULT;
          else begin
            h_off_q <= g_wide ? g_off : {16'h0, g_off[15:0]};
            h_sel_q <= g_sel;
            wide_q  <= g_wide;
            st_q    <= ST_DESC_LO;
          end
        end
        ST_DESC_LO: if (mem_ack_i) begin
          d_lo_q <= mem_rdata_i;
          st_q   <= ST_DESC_HI;
        end
        ST_DESC_HI: if (mem_ack_i) begin
          cs_base_o  <= s_base;
          cs_limit_o <= s_limit;
          cs_attr_o  <= s_attr;
          st_q       <= ST_PUSH;
        end
        ST_PUSH: if (mem_ack_i) begin
          if (step_q == LAST_STEP) begin
            new_cs_o <= h_sel_q;
            new_ip_o <= h_off_q;
            new_sp_o <= sp_q - frame_bytes;
            st_q     <= ST_DONE;
          end else step_q <= step_q + 2'd1;
        end
        ST_POP: if (mem_ack_i) begin
          unique case (step_q)
            2'd0: pop_ip_q <= mem_rdata_i;
            2'd1: pop_cs_q <= mem_rdata_i[15:0];
            default: begin
              new_ip_o    <= wide_q ? pop_ip_q : {16'h0, pop_ip_q[15:0]};
              new_cs_o    <= pop_cs_q;
              new_flags_o <= wide_q ? mem_rdata_i
                                    : {flags_q[31:16], mem_rdata_i[15:0]};
              new_sp_o    <= sp_q + frame_bytes;
            end
          endcase
          if (step_q == LAST_STEP) st_q <= ST_DONE;
          else step_q <= step_q + 2'd1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intr_entry_seq_chk.sv
module intr_entry_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          fault_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_wide_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   new_ip_o
);
  logic wr_seen, wr16_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_seen <= 1'b0; wr16_seen <= 1'b0;
    end else if (!busy_o) begin
      wr_seen <= 1'b0; wr16_seen <= 1'b0;
    end else if (mem_req_o && mem_we_o) begin
      wr_seen <= 1'b1;
      if (!mem_wide_o) wr16_seen <= 1'b1;
    end
  end

  assert_req_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  assert_ip_zext_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && wr16_seen |-> new_ip_o[31:16] == 16'h0);

  assert_fault_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !wr_seen);

  assert_end_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
endmodule

bind intr_entry_seq intr_entry_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .fault_o(fault_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_wide_o(mem_wide_o), .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o),
  .new_ip_o(new_ip_o)
);

// File: tb/intr_entry_seq_bench.sv
module intr_entry_seq_bench;
  localparam int AW = 32;
  localparam logic [31:0] GDT = 32'h800;
  localparam logic [31:0] LDT = 32'hC00;

  typedef struct packed {
    logic        pm;
    logic [7:0]  vec;
    logic [3:0]  gt;
    logic [31:0] off;
    logic [15:0] sel;
    logic [31:0] ip;
    logic [31:0] flg;
    logic [15:0] cs;
    logic [31:0] sp;
    logic        dbit;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 8'h03, 4'h6, 32'h1234ABCD, 16'h0010, 32'hDEAD5678, 32'h00230246, 16'h0008, 32'h00001000, 1'b1},
    '{1'b1, 8'h20, 4'hE, 32'h1234ABCD, 16'h0014, 32'hCAFE0010, 32'h00010202, 16'h001B, 32'h00001800, 1'b0},
    '{1'b1, 8'hFF, 4'hE, 32'h80000004, 16'h0028, 32'h00000FFE, 32'h00200086, 16'hFFF0, 32'h00001F00, 1'b1},
    '{1'b1, 8'h05, 4'h6, 32'hFFFF0002, 16'h001F, 32'h0001FFFF, 32'h0000F0D7, 16'h0023, 32'h00001200, 1'b0},
    '{1'b0, 8'h08, 4'hE, 32'h5555C0DE, 16'hF000, 32'h12348765, 32'h00270046, 16'h0700, 32'h00001400, 1'b1},
    '{1'b1, 8'h09, 4'hF, 32'h00000100, 16'h0030, 32'h00000111, 32'h00000002, 16'h0001, 32'h00001600, 1'b0},
    '{1'b1, 8'h0A, 4'h0, 32'h00000200, 16'h0030, 32'h00000222, 32'h00000002, 16'h0002, 32'h00001700, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic prot_en = 1'b0, irq_req = 1'b0, iret_req = 1'b0, iret_wide = 1'b0;
  logic [7:0]  irq_vec = '0;
  logic [15:0] cur_cs = '0;
  logic [31:0] cur_ip = '0, cur_flags = '0, cur_sp = '0;
  logic        mem_req, mem_we, mem_wide, busy, done, fault;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [15:0] new_cs;
  logic [31:0] new_ip, new_flags, new_sp, cs_base;
  logic [19:0] cs_limit;
  logic [11:0] cs_attr;

  intr_entry_seq #(.AW(AW), .VEC_W(8)) u_intr_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .prot_en_i(prot_en),
    .gate_base_i(32'h0), .gdt_base_i(GDT), .ldt_base_i(LDT),
    .irq_req_i(irq_req), .irq_vec_i(irq_vec), .iret_req_i(iret_req),
    .iret_wide_i(iret_wide), .cur_cs_i(cur_cs), .cur_ip_i(cur_ip),
    .cur_flags_i(cur_flags), .cur_sp_i(cur_sp),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wide_o(mem_wide),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .fault_o(fault),
    .new_cs_o(new_cs), .new_ip_o(new_ip), .new_flags_o(new_flags),
    .new_sp_o(new_sp), .cs_base_o(cs_base), .cs_limit_o(cs_limit),
    .cs_attr_o(cs_attr)
  );

  // memory model: 8 KiB, one-cycle acknowledge, pokes for setup
  logic [7:0]  mem [0:8191];
  logic        poke_en = 1'b0;
  logic [12:0] poke_a = '0;
  logic [31:0] poke_d = '0;
  logic [12:0] ma;
  int          wr_cnt = 0;
  assign ma = mem_addr[12:0];

  always @(posedge clk) begin
    if (poke_en) begin
      mem[poke_a] <= poke_d[7:0];          mem[poke_a + 13'd1] <= poke_d[15:8];
      mem[poke_a + 13'd2] <= poke_d[23:16]; mem[poke_a + 13'd3] <= poke_d[31:24];
    end
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= {mem[ma + 13'd3], mem[ma + 13'd2], mem[ma + 13'd1], mem[ma]};
      if (mem_we) begin
        wr_cnt <= wr_cnt + 1;
        mem[ma] <= mem_wdata[7:0]; mem[ma + 13'd1] <= mem_wdata[15:8];
        if (mem_wide) begin
          mem[ma + 13'd2] <= mem_wdata[23:16]; mem[ma + 13'd3] <= mem_wdata[31:24];
        end
      end
    end else mem_ack <= 1'b0;
  end

  int n_chk = 0, n_fail = 0;

  function automatic logic [15:0] rd16(input logic [31:0] a);
    return {mem[a[12:0] + 13'd1], mem[a[12:0]]};
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {mem[a[12:0] + 13'd3], mem[a[12:0] + 13'd2], mem[a[12:0] + 13'd1], mem[a[12:0]]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = a[12:0]; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic wait_end(output int nd, output int nf);
    nd = 0; nf = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (done) nd++;
      if (fault) nf++;
      if ((nd + nf) > 0 && !busy) break;
    end
    if (nd + nf == 0) begin
      n_chk++; n_fail++;
      $display("FAIL R11: no completion pulse, actual 0 expected 1");
    end
  endtask

  task automatic fire_irq(input vec_t v);
    @(negedge clk);
    prot_en = v.pm; irq_vec = v.vec; cur_cs = v.cs; cur_ip = v.ip;
    cur_flags = v.flg; cur_sp = v.sp; irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  vec_t        v;
  logic [31:0] dbase, daddr, w, p_ip, p_sp;
  logic [19:0] dlim;
  logic [11:0] dattr;
  logic [15:0] p_cs;
  logic        valid, wide;
  int          nd, nf, w0;

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    check("R12 busy", {31'h0, busy}, 32'h0);
    check("R12 req", {31'h0, mem_req}, 32'h0);
    check("R12 pulses", {30'h0, done, fault}, 32'h0);
    check("R12 new_ip", new_ip, 32'h0);
    check("R12 new_sp", new_sp, 32'h0);
    check("R12 cache", cs_base | {12'h0, cs_limit} | {20'h0, cs_attr}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 7; i++) begin
      v     = VECS[i];
      dbase = 32'h00100000 + 32'(i) * 32'h00011000;
      dlim  = 20'hA5A5A ^ 20'(i);
      dattr = {1'b1, v.dbit, 2'b00, 8'h9B};
      daddr = (v.sel[2] ? LDT : GDT) + {16'h0, v.sel[15:3], 3'b000};
      if (v.pm) begin
        poke({21'h0, v.vec, 3'b000}, {v.sel, v.off[15:0]});
        poke({21'h0, v.vec, 3'b100}, {v.off[31:16], 4'h8, v.gt, 8'h00});
        poke(daddr, {dbase[15:0], dlim[15:0]});
        poke(daddr + 32'd4, {dbase[31:24], dattr[11:8], dlim[19:16], dattr[7:0], dbase[23:16]});
      end else begin
        poke({22'h0, v.vec, 2'b00}, {v.sel, v.off[15:0]});
        poke({22'h0, v.vec, 2'b00} + 32'h4, {v.off[31:16], 4'h8, v.gt, 8'h00});
      end
      p_ip = new_ip; p_cs = new_cs; p_sp = new_sp; w0 = wr_cnt;
      fire_irq(v);
      wait_end(nd, nf);
      valid = !v.pm || v.gt == 4'h6 || v.gt == 4'hE;
      wide  = v.pm && v.gt == 4'hE;
      w     = wide ? 32'd4 : 32'd2;
      if (!valid) begin
        check("R8 fault pulse", nf, 1);
        check("R8 no done", nd, 0);
        check("R8 no writes", wr_cnt - w0, 0);
        check("R8 ip kept", new_ip, p_ip);
        check("R8 cs kept", {16'h0, new_cs}, {16'h0, p_cs});
        check("R8 sp kept", new_sp, p_sp);
      end else begin
        check("R11 one done", nd, 1);
        check("R11 no fault", nf, 0);
        check("R1 new cs", {16'h0, new_cs}, {16'h0, v.sel});
        check("R4 new ip", new_ip, wide ? v.off : {16'h0, v.off[15:0]});
        check(wide ? "R3 R6 sp" : "R2 R6 sp", new_sp, v.sp - 3 * w);
        check("R2 R3 write count", wr_cnt - w0, 3);
        if (wide) begin
          check("R3 flags slot", rd32(v.sp - 4), v.flg);
          check("R3 cs slot", rd32(v.sp - 8), {16'h0, v.cs});
          check("R3 ip slot", rd32(v.sp - 12), v.ip);
        end else begin
          check(v.pm ? "R2 flags slot" : "R7 flags slot", {16'h0, rd16(v.sp - 2)}, {16'h0, v.flg[15:0]});
          check(v.pm ? "R2 cs slot" : "R7 cs slot", {16'h0, rd16(v.sp - 4)}, {16'h0, v.cs});
          check(v.pm ? "R2 ip slot" : "R7 ip slot", {16'h0, rd16(v.sp - 6)}, {16'h0, v.ip[15:0]});
        end
        if (v.pm) begin
          check("R5 cache base", cs_base, dbase);
          check("R5 cache limit", {12'h0, cs_limit}, {12'h0, dlim});
          check("R5 cache attr", {20'h0, cs_attr}, {20'h0, dattr});
        end else begin
          check("R7 cache base", cs_base, {12'h0, v.sel, 4'h0});
          check("R7 cache limit", {12'h0, cs_limit}, 32'h0FFFF);
        end
      end
    end

    // R10: 32-bit return with junk in upper selector half
    poke(32'h1A00, 32'h89ABCDEF);
    poke(32'h1A04, 32'hFFFF0033);
    poke(32'h1A08, 32'h00000246);
    w0 = wr_cnt;
    @(negedge clk);
    cur_sp = 32'h1A00; cur_flags = 32'h00FF0000; iret_wide = 1'b1; iret_req = 1'b1;
    @(negedge clk);
    iret_req = 1'b0;
    wait_end(nd, nf);
    check("R10 done", nd, 1);
    check("R10 ip", new_ip, 32'h89ABCDEF);
    check("R10 cs", {16'h0, new_cs}, 32'h0033);
    check("R10 flags", new_flags, 32'h00000246);
    check("R10 sp", new_sp, 32'h1A0C);
    check("R10 no writes", wr_cnt - w0, 0);

    // R9: 16-bit return, upper IP and flags come from elsewhere
    poke(32'h1B00, 32'h00424321);
    poke(32'h1B04, 32'hBEEF0893);
    @(negedge clk);
    cur_sp = 32'h1B00; cur_flags = 32'h0024FFFF; iret_wide = 1'b0; iret_req = 1'b1;
    @(negedge clk);
    iret_req = 1'b0;
    wait_end(nd, nf);
    check("R9 ip", new_ip, 32'h00004321);
    check("R9 cs", {16'h0, new_cs}, 32'h0042);
    check("R9 flags", new_flags, 32'h00240893);
    check("R9 sp", new_sp, 32'h1B06);

    // R11: requests during a busy sequence are ignored
    v = VECS[0];
    v.sp = 32'h1300;
    fire_irq(v);
    @(negedge clk);
    irq_vec = 8'h20; cur_sp = 32'h1A00; irq_req = 1'b1; iret_req = 1'b1; iret_wide = 1'b1;
    @(negedge clk);
    irq_req = 1'b0; iret_req = 1'b0;
    wait_end(nd, nf);
    check("R11 single done", nd, 1);
    check("R11 first cs", {16'h0, new_cs}, 32'h0010);
    check("R11 first ip", new_ip, 32'h0000ABCD);
    check("R11 first sp", new_sp, 32'h12FA);
    repeat (4) @(negedge clk);
    check("R11 stays idle", {31'h0, busy}, 32'h0);

    // R12: asynchronous reset mid-sequence returns to reset state
    fire_irq(VECS[1]);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 reset req", {31'h0, mem_req}, 32'h0);
    check("R12 reset sp", new_sp, 32'h0);
    rst_n = 1'b1;

    finish_run();
  end
endmodule